// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the sampling enables of a serial receiver and transmitter from one fixed reference clock. Software programs a divisor made of a 16-bit whole part and a 6-bit part counted in 64ths. The generator then emits a one-cycle oversampling tick at sixteen times the bit rate, and a bit tick on every sixteenth of those. Whole-part division alone cannot reach most rates. To cover them, a small accumulator adds the fraction once per oversampling period. Each carry out of the accumulator lengthens the next period by one reference clock, so the mean rate matches the programmed value.

The two divisor halves are written into holding registers through a plain write port. They are not used until a later write to the commit address copies both into the active divisor at once. That write also restarts the period counter, the accumulator and the divide-by-sixteen counter. A reference of 14.7456 MHz with whole part 8 gives 115200 baud, and whole part 96 gives 9600. A 3 MHz reference needs 1 + 40/64 for 115200 and 19 + 34/64 for 9600.

Top module: `frac_baud_gen`

## Requirements
- R1: After the active-low reset, and until the first commit, both tick outputs stay low.
- R2: The write port decodes `wr_addr` as 0 = whole divisor (all 16 bits of `wr_data`), 1 = fraction (`wr_data[5:0]`, upper bits ignored), 2 = commit, and 3 = no effect. Writes to addresses 0, 1 and 3 leave the tick pattern unchanged until a commit.
- R3: With fraction 0 and whole part I ≥ 1, the first oversampling tick is high in the I-th cycle after the commit edge, and ticks then repeat every I cycles.
- R4: Whatever the fraction F, the 65th oversampling tick after a commit falls exactly 65·I + F cycles after the commit edge. A period is one cycle longer exactly when the previous accumulation carried out of 6 bits.
- R5: `baud_tick` is high only together with `baud16_tick`, and it is high on every 16th oversampling tick counted from the commit, starting with the 16th.
- R6: While the active whole part is 0, neither tick is ever produced.
- R7: A commit restarts the period count, the accumulator and the sixteenth count. A tick that falls in the commit cycle is still output, and the next period follows the new divisor in full.
- R8: With whole part 1 and fraction 0, `baud16_tick` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 whole, 1 fraction, 2 commit, 3 unused |
| wr_data | input | 16 | Write data |
| baud16_tick | output | 1 | One-cycle oversampling enable |
| baud_tick | output | 1 | Bit-rate enable, coincident with every 16th oversampling tick |

## Verification
The commit write can land in the same cycle as a period's final count. It can also land on the cycle where the sixteenth oversampling tick raises `baud_tick`. The bench provokes both cases by watching the outputs at the falling edge and issuing the commit in that very cycle. The behavioural model then predicts two things: the tick of the old period still shows in that cycle, and the next full period and the sixteenth count follow the new divisor. Every cycle is compared against that prediction, and the measured cycles to the 65th tick are checked against 65·I + F.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  typedef enum logic [1:0] {
    REG_WHOLE  = 2'd0,
    REG_FRAC   = 2'd1,
    REG_COMMIT = 2'd2,
    REG_SPARE  = 2'd3
  } fbg_reg_e;
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
#(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [INT_W-1:0]  wr_data,
  output logic              commit,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac
);
  logic [INT_W-1:0]  stg_int;
  logic [FRAC_W-1:0] stg_frac;

  // R2: only address 2 moves the staged pair into use
  assign commit = wr_en && (wr_addr == REG_COMMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_int  <= '0;
      stg_frac <= '0;
      act_int  <= '0;
      act_frac <= '0;
    end else begin
      if (wr_en && (wr_addr == REG_WHOLE)) stg_int  <= wr_data;
      if (wr_en && (wr_addr == REG_FRAC))  stg_frac <= wr_data[FRAC_W-1:0];
      if (commit) begin
        act_int  <= stg_int;
        act_frac <= stg_frac;
      end
    end
  end
endmodule

// File: rtl/fbg_period.sv
module fbg_period #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick,
  output logic              ext_o
);
  localparam int unsigned CW = INT_W + 1;

  // final count of a period: whole part minus one, plus the pending extension
  function automatic logic [CW-1:0] last_count(input logic [INT_W-1:0] d,
                                               input logic e);
    return {1'b0, d} - CW'(1) + CW'(e);
  endfunction

  // accumulator step: carry in the top bit
  function automatic logic [FRAC_W:0] accumulate(input logic [FRAC_W-1:0] a,
                                                 input logic [FRAC_W-1:0] f);
    return {1'b0, a} + {1'b0, f};
  endfunction

  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic              ext;
  logic [FRAC_W:0]   acc_sum;

  assign acc_sum = accumulate(acc, div_frac);
  // R6: no tick with a zero whole part
  assign tick    = (div_int != '0) && ({1'b0, cnt} == last_count(div_int, ext));
  assign ext_o   = ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
      ext <= 1'b0;
    end else if (restart) begin          // R7
      cnt <= '0;
      acc <= '0;
      ext <= 1'b0;
    end else if (div_int == '0) begin
      cnt <= '0;
    end else if (tick) begin             // R4: carry lengthens next period
      cnt <= '0;
      acc <= acc_sum[FRAC_W-1:0];
      ext <= acc_sum[FRAC_W];
    end else begin
      cnt <= cnt + INT_W'(1);
    end
  end
endmodule

// File: rtl/fbg_subdiv.sv
module fbg_subdiv #(
  parameter int unsigned RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick_in,
  output logic tick_out
);
  localparam int unsigned SW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [SW-1:0] TOP = SW'(RATIO - 1);

  logic [SW-1:0] sub;

  // R5: bit tick rides on the last oversampling tick of each group
  assign tick_out = tick_in && (sub == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sub <= '0;
    else if (restart)    sub <= '0;
    else if (tick_in)    sub <= (sub == TOP) ? '0 : sub + SW'(1);
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6,
  parameter int unsigned OVS    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [INT_W-1:0] wr_data,
  output logic             baud16_tick,
  output logic             baud_tick
);
  logic              commit;
  logic [INT_W-1:0]  act_int;
  logic [FRAC_W-1:0] act_frac;
  logic              period_ext;

  fbg_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .act_int(act_int), .act_frac(act_frac)
  );

  fbg_period #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_period (
    .clk(clk), .rst_n(rst_n), .restart(commit), .div_int(act_int),
    .div_frac(act_frac), .tick(baud16_tick), .ext_o(period_ext)
  );

  fbg_subdiv #(.RATIO(OVS)) u_subdiv (
    .clk(clk), .rst_n(rst_n), .restart(commit),
    .tick_in(baud16_tick), .tick_out(baud_tick)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic [INT_W-1:0]  act_int,
  input logic [FRAC_W-1:0] act_frac,
  input logic              period_ext,
  input logic              baud16_tick,
  input logic              baud_tick
);
  p_hold_staged_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_int) && $stable(act_frac)));

  p_gap_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (baud16_tick && !commit && (act_int > INT_W'(1))) |=> !baud16_tick);

  p_no_ext_at_zero_frac_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_frac == '0) |-> !period_ext);

  p_bit_on_os_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> baud16_tick);

  p_silent_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_int == '0) |-> (!baud16_tick && !baud_tick));

  p_fresh_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(commit) && (act_int > INT_W'(1))) |-> !baud16_tick);
endmodule

bind frac_baud_gen fbg_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_fbg_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .act_int(act_int),
  .act_frac(act_frac), .period_ext(period_ext),
  .baud16_tick(baud16_tick), .baud_tick(baud_tick)
);

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        baud16_tick;
  logic        baud_tick;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  frac_baud_gen i_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .baud16_tick(baud16_tick), .baud_tick(baud_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model: elapsed cycles in period, running fraction sum
  int m_hold_i = 0, m_hold_f = 0, m_i = 0, m_f = 0;
  int m_elapsed = 0, m_frac_sum = 0, m_long = 0, m_seen = 0;

  function automatic bit exp_os();
    return (m_i != 0) && (m_elapsed == m_i - 1 + m_long);
  endfunction
  function automatic bit exp_bit();
    return exp_os() && (m_seen == 15);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold_i = 0; m_hold_f = 0; m_i = 0; m_f = 0;
      m_elapsed = 0; m_frac_sum = 0; m_long = 0; m_seen = 0;
    end else begin
      bit os_now;
      bit go;
      os_now = exp_os();
      go = wr_en && (wr_addr == 2'd2);
      if (wr_en && wr_addr == 2'd0) m_hold_i = int'(wr_data);
      if (wr_en && wr_addr == 2'd1) m_hold_f = int'(wr_data) % 64;
      if (go) begin
        m_i = m_hold_i; m_f = m_hold_f;
        m_elapsed = 0; m_frac_sum = 0; m_long = 0; m_seen = 0;
      end else if (m_i == 0) begin
        m_elapsed = 0;
      end else if (os_now) begin
        m_frac_sum = m_frac_sum + m_f;
        m_long = (m_frac_sum >= 64) ? 1 : 0;
        m_frac_sum = m_frac_sum % 64;
        m_elapsed = 0;
        m_seen = (m_seen + 1) % 16;
      end else begin
        m_elapsed = m_elapsed + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (baud16_tick !== exp_os() || baud_tick !== exp_bit()) begin
        mismatched++;
        $display("FAIL %s: got os=%0b bit=%0b expected os=%0b bit=%0b at %0t",
                 cur_req, baud16_tick, baud_tick, exp_os(), exp_bit(), $time);
      end
    end
  end

  task automatic put(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 16'd0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic setup(input int wi, input int fr);
    @(negedge clk); put(2'd0, 16'(wi));
    put(2'd1, 16'(fr));
  endtask

  // commit now, then count cycles to the n-th oversampling tick
  task automatic commit_measure(input int n, output int cyc, output int bits);
    int seen;
    put(2'd2, 16'd0);
    cyc = 1; seen = 0; bits = 0;
    forever begin
      if (baud16_tick) seen++;
      if (baud_tick) bits++;
      if (seen == n) break;
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic expect_int(input string req, input int got, input int want);
    compared++;
    if (got != want) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", req, got, want);
    end
  endtask

  initial begin
    int cyc, bits;
    idle(4);
    compared++;
    if (baud16_tick !== 1'b0 || baud_tick !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: got %0b%0b expected 00 in reset", baud16_tick, baud_tick);
    end
    rst_n = 1'b1;
    idle(40);                                  // R1: silent before commit

    cur_req = "R2";
    setup(8, 0);
    put(2'd3, 16'h0005);
    idle(30);                                  // staged only, still silent

    cur_req = "R3";
    @(negedge clk);
    commit_measure(1, cyc, bits);
    expect_int("R3 first tick", cyc, 8);
    @(negedge clk);
    commit_measure(16, cyc, bits);
    expect_int("R5 sixteenth", cyc, 128);
    expect_int("R5 bit count", bits, 1);
    @(negedge clk);
    commit_measure(65, cyc, bits);
    expect_int("R4 whole only", cyc, 520);

    cur_req = "R4";
    setup(1, 40);
    commit_measure(65, cyc, bits);
    expect_int("R4 1+40/64", cyc, 105);
    expect_int("R5 bits 65", bits, 4);
    setup(19, 34);
    commit_measure(65, cyc, bits);
    expect_int("R4 19+34/64", cyc, 1269);
    setup(2, 16'hFFE0);                        // upper bits dropped: F=32
    commit_measure(65, cyc, bits);
    expect_int("R2 frac upper ignored", cyc, 162);

    cur_req = "R2";
    setup(3, 0);
    idle(60);                                  // old 2+32/64 keeps running
    setup(4, 0);

    cur_req = "R6";
    setup(0, 10);
    put(2'd2, 16'd0);
    idle(80);

    cur_req = "R7";
    setup(4, 0);
    put(2'd2, 16'd0);
    setup(5, 0);
    do @(negedge clk); while (!baud16_tick);
    put(2'd2, 16'd0);                          // commit collides with a tick
    idle(120);
    setup(3, 7);
    do @(negedge clk); while (!baud_tick);
    put(2'd2, 16'd0);                          // commit collides with bit tick
    idle(200);

    cur_req = "R8";
    setup(1, 0);
    commit_measure(32, cyc, bits);
    expect_int("R8 every cycle", cyc, 32);
    expect_int("R8 bits", bits, 2);
    idle(20);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule